// File: doc/BRIEF.md
# Doubleword Atomic Read-Modify-Write Unit

This unit carries out 64-bit atomic read-modify-write instructions for a 64-bit core. The core presents a 32-bit instruction word together with the values of its two source registers. The unit decodes the operation and reads the doubleword at the address held in the first source value. It hands the old memory contents back for the destination register, then computes the new value from the old one and the second source value and writes it to the same address.

Memory is reached through a plain synchronous port. A request is issued for one cycle, and read data comes back some cycles later, marked by a valid strobe. Only one instruction is in flight at a time. While the unit is busy it ignores new requests. Every accepted instruction ends with a one-cycle done pulse. Reservation-based load and store-conditional encodings are recognised but not executed: the unit flags them for a separate reservation block. Any other encoding is flagged as illegal, and neither case touches memory.

Top module: `amo_dword_unit`

## Requirements
- R1: An instruction is recognised only when bits 6:0 equal 0101111 and bits 14:12 equal 011. Any other word completes with the illegal flag at done and makes no memory request.
- R2: Bits 31:27 pick the operation: 00001 swap, 00000 add, 00100 xor, 01100 and, 01000 or, 10000 signed min, 10100 signed max, 11000 unsigned min, 11100 unsigned max. The destination index is bits 11:7.
- R3: The memory address is the full 64-bit first source value. Every access moves a whole 64-bit doubleword.
- R4: At done the unit presents the memory value read before modification as destination data. The register write-enable is high only in the done cycle, and only when the destination index is nonzero.
- R5: Swap writes the second source value. Add, xor, and and or write the old value combined with the second source value by that operation, with the add wrapping modulo 2^64.
- R6: Signed min and signed max compare the old value and the second source value as two's-complement numbers, and write the selected operand back.
- R7: Unsigned min and unsigned max compare the same operands as unsigned numbers, and write the selected operand back.
- R8: The operation runs through exactly one read request, a wait for read data, exactly one write request after that data has returned, and a single-cycle done pulse. Requests that arrive while the unit is busy are ignored.
- R9: A recognised word whose function code is not among those in R2 or R11 completes with the illegal flag. It makes no memory request and does not write a register.
- R10: The acquire flag (bit 26) and the release flag (bit 25) of the accepted word appear unchanged on their outputs at done. They do not change the sequence.
- R11: Function codes 00010 and 00011 in a recognised word complete with the reservation hand-off flag and no illegal flag. They make no memory request and do not write a register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Instruction request, taken when not busy |
| instr_i | input | 32 | Instruction word |
| rs1_val_i | input | 64 | First source value (address) |
| rs2_val_i | input | 64 | Second source value (operand) |
| busy_o | output | 1 | Unit holds an instruction |
| mem_req_o | output | 1 | Memory request strobe |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 64 | Memory address |
| mem_wdata_o | output | 64 | Write data |
| mem_rdata_i | input | 64 | Read data |
| mem_rvalid_i | input | 1 | Read data valid |
| done_o | output | 1 | Instruction complete, one cycle |
| rd_we_o | output | 1 | Destination register write-enable |
| rd_addr_o | output | 5 | Destination register index |
| rd_data_o | output | 64 | Old memory value for the destination |
| illegal_o | output | 1 | Illegal instruction, valid with done |
| lrsc_o | output | 1 | Reservation hand-off, valid with done |
| aq_o | output | 1 | Acquire flag of the held instruction |
| rl_o | output | 1 | Release flag of the held instruction |

## Verification
Some properties are checked on every cycle. Writes happen only after read data has come back, a read request lasts one cycle, and the done pulse also lasts one cycle. The register write is gated to done with a nonzero index, and an illegal completion follows no memory request. The written value of signed min and unsigned max is bounded by both operands. Other behaviour can only be shown by the bench's scenarios, because it depends on exact data: each operation's result on chosen operands (wraparound, sign boundaries, equal operands), the returned old value, the flag passthrough, the hand-off and illegal encodings, and a request ignored while busy.

// File: rtl/amo_pkg.sv
package amo_pkg;
  localparam logic [6:0] OPC_ATOMIC = 7'b0101111;
  localparam logic [2:0] WIDTH_DW   = 3'b011;

  localparam logic [4:0] FN_ADD  = 5'b00000;
  localparam logic [4:0] FN_SWAP = 5'b00001;
  localparam logic [4:0] FN_LR   = 5'b00010;
  localparam logic [4:0] FN_SC   = 5'b00011;
  localparam logic [4:0] FN_XOR  = 5'b00100;
  localparam logic [4:0] FN_OR   = 5'b01000;
  localparam logic [4:0] FN_AND  = 5'b01100;
  localparam logic [4:0] FN_MIN  = 5'b10000;
  localparam logic [4:0] FN_MAX  = 5'b10100;
  localparam logic [4:0] FN_MINU = 5'b11000;
  localparam logic [4:0] FN_MAXU = 5'b11100;

  typedef enum logic [2:0] {ST_IDLE, ST_READ, ST_WAIT, ST_WRITE, ST_DONE} amo_state_e;

  typedef enum logic [3:0] {
    OP_SWAP, OP_ADD, OP_XOR, OP_AND, OP_OR,
    OP_MIN, OP_MAX, OP_MINU, OP_MAXU, OP_NONE
  } amo_op_e;

  typedef struct packed {
    amo_op_e    op;
    logic       run;      // legal read-modify-write
    logic       lrsc;
    logic       illegal;
    logic       aq;
    logic       rl;
    logic [4:0] rd;
  } amo_dec_t;
endpackage

// File: rtl/amo_decode.sv
module amo_decode
  import amo_pkg::*;
(
  input  logic [31:0] instr_i,
  output amo_dec_t    dec_o
);
  logic    match;
  amo_op_e op;
  logic    is_lrsc;

  assign match = (instr_i[6:0] == OPC_ATOMIC) && (instr_i[14:12] == WIDTH_DW);

  always_comb begin
    op      = OP_NONE;
    is_lrsc = 1'b0;
    unique case (instr_i[31:27])
      FN_SWAP: op = OP_SWAP;
      FN_ADD:  op = OP_ADD;
      FN_XOR:  op = OP_XOR;
      FN_AND:  op = OP_AND;
      FN_OR:   op = OP_OR;
      FN_MIN:  op = OP_MIN;
      FN_MAX:  op = OP_MAX;
      FN_MINU: op = OP_MINU;
      FN_MAXU: op = OP_MAXU;
      FN_LR, FN_SC: is_lrsc = 1'b1;
      default: op = OP_NONE;
    endcase
  end

  always_comb begin
    dec_o.op      = op;
    dec_o.run     = match && (op != OP_NONE);
    dec_o.lrsc    = match && is_lrsc;
    dec_o.illegal = !match || ((op == OP_NONE) && !is_lrsc);
    dec_o.aq      = instr_i[26];
    dec_o.rl      = instr_i[25];
    dec_o.rd      = instr_i[11:7];
  end
endmodule

// File: rtl/amo_alu.sv
module amo_alu
  import amo_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  amo_op_e           op_i,
  input  logic [DATA_W-1:0] old_i,
  input  logic [DATA_W-1:0] opnd_i,
  output logic [DATA_W-1:0] res_o
);
  logic s_lt, u_lt;

  assign s_lt = $signed(old_i) < $signed(opnd_i);
  assign u_lt = old_i < opnd_i;

  always_comb begin
    unique case (op_i)
      OP_SWAP: res_o = opnd_i;
      OP_ADD:  res_o = old_i + opnd_i;
      OP_XOR:  res_o = old_i ^ opnd_i;
      OP_AND:  res_o = old_i & opnd_i;
      OP_OR:   res_o = old_i | opnd_i;
      OP_MIN:  res_o = s_lt ? old_i : opnd_i;
      OP_MAX:  res_o = s_lt ? opnd_i : old_i;
      OP_MINU: res_o = u_lt ? old_i : opnd_i;
      OP_MAXU: res_o = u_lt ? opnd_i : old_i;
      default: res_o = old_i;
    endcase
  end
endmodule

// File: rtl/amo_ctrl.sv
module amo_ctrl
  import amo_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_valid_i,
  input  logic       run_i,
  input  logic       rvalid_i,
  output amo_state_e state_o
);
  amo_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (req_valid_i) state_d = run_i ? ST_READ : ST_DONE;
      ST_READ:  state_d = ST_WAIT;
      ST_WAIT:  if (rvalid_i) state_d = ST_WRITE;
      ST_WRITE: state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  AST_WRITE_AFTER_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WRITE) |-> $past(rvalid_i)); // R8
endmodule

// File: rtl/amo_dword_unit.sv
module amo_dword_unit
  import amo_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int INSN_W = 32,
  parameter int REG_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [INSN_W-1:0] instr_i,
  input  logic [DATA_W-1:0] rs1_val_i,
  input  logic [DATA_W-1:0] rs2_val_i,
  output logic              busy_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [DATA_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_rvalid_i,
  output logic              done_o,
  output logic              rd_we_o,
  output logic [REG_W-1:0]  rd_addr_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              illegal_o,
  output logic              lrsc_o,
  output logic              aq_o,
  output logic              rl_o
);
  amo_dec_t          dec, dec_q;
  amo_state_e        state;
  logic              accept;
  logic [DATA_W-1:0] rs1_q, rs2_q, old_q, new_val;

  amo_decode u_dec (.instr_i(instr_i[31:0]), .dec_o(dec));

  amo_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_valid_i(req_valid_i),
    .run_i      (dec.run),
    .rvalid_i   (mem_rvalid_i),
    .state_o    (state)
  );

  amo_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i  (dec_q.op),
    .old_i (old_q),
    .opnd_i(rs2_q),
    .res_o (new_val)
  );

  assign accept = req_valid_i && (state == ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dec_q <= '{op: OP_NONE, default: '0};
      rs1_q <= '0;
      rs2_q <= '0;
    end else if (accept) begin
      dec_q <= dec;
      rs1_q <= rs1_val_i;
      rs2_q <= rs2_val_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                old_q <= '0;
    else if (state == ST_WAIT && mem_rvalid_i) old_q <= mem_rdata_i;
  end

  assign busy_o      = (state != ST_IDLE);
  assign mem_req_o   = (state == ST_READ) || (state == ST_WRITE);
  assign mem_we_o    = (state == ST_WRITE);
  assign mem_addr_o  = rs1_q;
  assign mem_wdata_o = new_val;
  assign done_o      = (state == ST_DONE);
  assign rd_we_o     = done_o && dec_q.run && (dec_q.rd != '0);
  assign rd_addr_o   = dec_q.rd;
  assign rd_data_o   = old_q;
  assign illegal_o   = done_o && dec_q.illegal;
  assign lrsc_o      = done_o && dec_q.lrsc;
  assign aq_o        = dec_q.aq;
  assign rl_o        = dec_q.rl;

  AST_RD_WE_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_we_o |-> done_o && (rd_addr_o != '0)); // R4
  AST_ILLEGAL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !rd_we_o && !$past(mem_req_o)); // R9
  AST_READ_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o) |=> !mem_req_o); // R8
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o); // R8
  AST_SMIN_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && dec_q.op == OP_MIN) |->
      ($signed(mem_wdata_o) <= $signed(old_q)) && ($signed(mem_wdata_o) <= $signed(rs2_q))); // R6
  AST_UMAX_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && dec_q.op == OP_MAXU) |->
      (mem_wdata_o >= old_q) && (mem_wdata_o >= rs2_q)); // R7
endmodule

// File: tb/sim_amo_dword_unit.sv
`timescale 1ns/1ps
module sim_amo_dword_unit;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [31:0] instr_i = '0;
  logic [63:0] rs1_val_i = '0, rs2_val_i = '0;
  logic [63:0] mem_rdata_i = '0;
  logic        mem_rvalid_i = 1'b0;
  logic        busy_o, mem_req_o, mem_we_o, done_o, rd_we_o, illegal_o, lrsc_o, aq_o, rl_o;
  logic [63:0] mem_addr_o, mem_wdata_o, rd_data_o;
  logic [4:0]  rd_addr_o;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  amo_dword_unit u0 (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .instr_i(instr_i),
    .rs1_val_i(rs1_val_i), .rs2_val_i(rs2_val_i), .busy_o(busy_o),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i), .mem_rvalid_i(mem_rvalid_i),
    .done_o(done_o), .rd_we_o(rd_we_o), .rd_addr_o(rd_addr_o), .rd_data_o(rd_data_o),
    .illegal_o(illegal_o), .lrsc_o(lrsc_o), .aq_o(aq_o), .rl_o(rl_o)
  );

  // {func, old memory value, rs2, expected written value}
  localparam int NV = 12;
  localparam logic [196:0] VEC [NV] = '{
    {5'b00001, 64'h0000_0000_0000_1111, 64'h0000_0000_0000_AAAA, 64'h0000_0000_0000_AAAA},
    {5'b00000, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0002, 64'h0000_0000_0000_0001},
    {5'b00000, 64'h0000_0000_0000_0010, 64'h0000_0000_0000_0020, 64'h0000_0000_0000_0030},
    {5'b00100, 64'h0000_0000_0000_F0F0, 64'h0000_0000_0000_0FF0, 64'h0000_0000_0000_FF00},
    {5'b01100, 64'h0000_0000_0000_F0F0, 64'h0000_0000_0000_0FF0, 64'h0000_0000_0000_00F0},
    {5'b01000, 64'h0000_0000_0000_F0F0, 64'h0000_0000_0000_0FF0, 64'h0000_0000_0000_FFF0},
    {5'b10000, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, 64'hFFFF_FFFF_FFFF_FFFF},
    {5'b10100, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_0001},
    {5'b11000, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_0001},
    {5'b11100, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, 64'hFFFF_FFFF_FFFF_FFFF},
    {5'b10000, 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000},
    {5'b11100, 64'h0000_0000_0000_0005, 64'h0000_0000_0000_0005, 64'h0000_0000_0000_0005}
  };

  // observations of one operation
  int          n_rd, n_wr;
  logic [63:0] o_raddr, o_waddr, o_wdata, o_rdata;
  logic        o_done, o_rdwe, o_ill, o_lrsc, o_aq, o_rl;
  logic [4:0]  o_rdaddr;

  function automatic logic [31:0] mk(input logic [4:0] fn, input logic aq, input logic rl,
                                     input logic [2:0] w, input logic [4:0] rd,
                                     input logic [6:0] opc);
    return {fn, aq, rl, 5'd7, 5'd6, w, rd, opc};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [31:0] ins, input logic [63:0] a, input logic [63:0] b,
                        input logic [63:0] old, input int lat, input bit poke);
    int cd = -1;
    n_rd = 0; n_wr = 0; o_done = 0; o_rdwe = 0; o_ill = 0; o_lrsc = 0;
    @(negedge clk);
    req_valid_i = 1'b1; instr_i = ins; rs1_val_i = a; rs2_val_i = b;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      req_valid_i  = 1'b0;
      mem_rvalid_i = 1'b0;
      if (poke && i == 2) begin
        req_valid_i = 1'b1;
        instr_i     = mk(5'b00001, 1'b0, 1'b0, 3'b011, 5'd9, 7'b0101111);
        rs1_val_i   = 64'hDEAD_0000_0000_0000;
      end
      if (cd > 0) begin
        cd--;
        if (cd == 0) begin mem_rvalid_i = 1'b1; mem_rdata_i = old; end
      end
      if (mem_req_o && !mem_we_o) begin n_rd++; o_raddr = mem_addr_o; cd = lat; end
      if (mem_req_o && mem_we_o)  begin n_wr++; o_waddr = mem_addr_o; o_wdata = mem_wdata_o; end
      if (done_o) begin
        o_done = 1; o_rdwe = rd_we_o; o_rdaddr = rd_addr_o; o_rdata = rd_data_o;
        o_ill = illegal_o; o_lrsc = lrsc_o; o_aq = aq_o; o_rl = rl_o;
        break;
      end
    end
    mem_rvalid_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // reset state
    chk(!busy_o && !mem_req_o && !done_o && !rd_we_o, "R8 reset idle", {60'd0, busy_o, mem_req_o, done_o, rd_we_o}, 64'd0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    // table walk: each op, varied read latency
    for (int v = 0; v < NV; v++) begin
      logic [63:0] addr = 64'hC000_0000_0000_0008 + 64'(v) * 64'h0000_0100_0000_0010;
      run_op(mk(VEC[v][196:192], 1'b0, 1'b0, 3'b011, 5'd5, 7'b0101111),
             addr, VEC[v][127:64], VEC[v][191:128], 1 + (v % 3), 1'b0);
      chk(o_done && n_rd == 1 && n_wr == 1, "R8 one read one write", 64'(n_rd * 16 + n_wr), 64'h11);
      chk(o_raddr == addr && o_waddr == addr, "R3 address", o_raddr, addr);
      chk(o_wdata == VEC[v][63:0], "R2/R5/R6/R7 written value", o_wdata, VEC[v][63:0]);
      chk(o_rdwe && o_rdaddr == 5'd5 && o_rdata == VEC[v][191:128], "R4 old value to rd", o_rdata, VEC[v][191:128]);
      chk(!o_ill && !o_lrsc, "R1 legal op not flagged", {62'd0, o_ill, o_lrsc}, 64'd0);
    end

    // R4: rd zero suppresses register write, memory still written
    run_op(mk(5'b00000, 1'b0, 1'b0, 3'b011, 5'd0, 7'b0101111), 64'h40, 64'd3, 64'd4, 2, 1'b0);
    chk(o_done && !o_rdwe && n_wr == 1 && o_wdata == 64'd7, "R4 rd zero no write", {63'd0, o_rdwe}, 64'd0);

    // R9: undefined function code
    run_op(mk(5'b00101, 1'b0, 1'b0, 3'b011, 5'd5, 7'b0101111), 64'h80, 64'd1, 64'd0, 1, 1'b0);
    chk(o_done && o_ill && !o_lrsc && !o_rdwe && n_rd == 0 && n_wr == 0, "R9 undefined func", {62'd0, o_ill, o_rdwe}, 64'h2);

    // R1: wrong opcode, wrong width
    run_op(mk(5'b00000, 1'b0, 1'b0, 3'b011, 5'd5, 7'b0110011), 64'h80, 64'd1, 64'd0, 1, 1'b0);
    chk(o_done && o_ill && n_rd == 0 && n_wr == 0 && !o_rdwe, "R1 bad opcode", {63'd0, o_ill}, 64'd1);
    run_op(mk(5'b00000, 1'b0, 1'b0, 3'b010, 5'd5, 7'b0101111), 64'h80, 64'd1, 64'd0, 1, 1'b0);
    chk(o_done && o_ill && n_rd == 0 && n_wr == 0 && !o_rdwe, "R1 bad width", {63'd0, o_ill}, 64'd1);

    // R11: reservation encodings handed off
    run_op(mk(5'b00010, 1'b0, 1'b0, 3'b011, 5'd5, 7'b0101111), 64'h80, 64'd0, 64'd0, 1, 1'b0);
    chk(o_done && o_lrsc && !o_ill && !o_rdwe && n_rd == 0, "R11 load-reserved handoff", {62'd0, o_lrsc, o_ill}, 64'h2);
    run_op(mk(5'b00011, 1'b0, 1'b0, 3'b011, 5'd5, 7'b0101111), 64'h80, 64'd9, 64'd0, 1, 1'b0);
    chk(o_done && o_lrsc && !o_ill && !o_rdwe && n_wr == 0, "R11 store-conditional handoff", {62'd0, o_lrsc, o_ill}, 64'h2);

    // R10: flag passthrough, both polarities
    run_op(mk(5'b01000, 1'b1, 1'b0, 3'b011, 5'd3, 7'b0101111), 64'h100, 64'd1, 64'd2, 1, 1'b0);
    chk(o_aq && !o_rl && o_wdata == 64'd3 && n_wr == 1, "R10 aq set rl clear", {62'd0, o_aq, o_rl}, 64'h2);
    run_op(mk(5'b01000, 1'b0, 1'b1, 3'b011, 5'd3, 7'b0101111), 64'h100, 64'd1, 64'd2, 3, 1'b0);
    chk(!o_aq && o_rl && o_wdata == 64'd3 && n_wr == 1, "R10 aq clear rl set", {62'd0, o_aq, o_rl}, 64'h1);

    // R8: request while busy is ignored
    run_op(mk(5'b00001, 1'b0, 1'b0, 3'b011, 5'd4, 7'b0101111), 64'h200, 64'd11, 64'd22, 3, 1'b1);
    chk(o_done && o_rdata == 64'd22 && o_raddr == 64'h200 && n_wr == 1, "R8 busy op completes", o_rdata, 64'd22);
    begin
      int extra = 0;
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        if (mem_req_o || done_o || busy_o) extra++;
      end
      chk(extra == 0, "R8 busy request ignored", 64'(extra), 64'd0);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule